// File: doc/BRIEF.md
# Lane Group Vote and Match Unit

This unit evaluates group-wide vote and equality operations for a group of 32 lanes that execute in lockstep. Every lane presents an active bit, a participation bit, a predicate bit and a 32-bit value. A single 3-bit operation code applies to the whole group. The unit computes one result, registers it, and delivers it to every lane that both participates and is active.

The available operations are:
- a predicate ballot;
- any-true and all-true reductions;
- match-any, where each lane gets a mask of the lanes holding its value;
- match-all, which reports whether all participating values are equal;
- a query of the currently active lanes.

Requests and responses use valid/ready handshakes. When the response side does not stall, one request can be accepted every cycle.

Top module: `warp_vote_unit`

## Requirements
- R1: Op code 0 (ballot): each effective lane receives a word whose bit j is lane j's predicate, taken only over effective lanes. A lane is effective when both its participation bit and its active bit are set. The scalar flag output is 0.
- R2: Op code 1 (any): the flag is 1 when at least one effective lane has its predicate set. Each effective lane receives the flag in bit 0 of its word, and the other bits are zero.
- R3: Op code 2 (all): the flag is 1 when every effective lane has its predicate set, and it is delivered in bit 0 as for R2. With no effective lane, all gives flag 1, any gives flag 0, ballot gives all-zero words, and match-all gives flag 1 with zero words.
- R4: Op code 3 (match-any): each effective lane i receives a mask with bit j set exactly when lane j is effective and lane j's value equals lane i's value. The flag is 0.
- R5: Op code 4 (match-all): the flag is 1 when all effective lanes hold the same value. In that case each effective lane receives the effective-lane mask; otherwise each receives zero.
- R6: Op code 5 (active query): each effective lane receives the full active vector, including active lanes that are not participating. The flag is 0.
- R7: A lane that is not effective always gets an all-zero result word. Lane i's word occupies bits i*32 to i*32+31 of the result output.
- R8: The response appears, with the response valid signal set, on the clock edge that accepts the request. Requests accepted on consecutive cycles give consecutive responses.
- R9: While a response is valid and the response side is not ready, the unit deasserts request ready and holds the response unchanged.
- R10: Op codes 6 and 7 give all-zero words, flag 0 and the error output set. Legal codes give error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_op_i | input | 3 | Operation code |
| active_i | input | 32 | Per-lane active bits |
| part_i | input | 32 | Per-lane participation bits |
| pred_i | input | 32 | Per-lane predicate bits |
| value_i | input | 1024 | Per-lane values, lane i at bits i*32 and up |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_result_o | output | 1024 | Per-lane result words, lane i at bits i*32 and up |
| rsp_flag_o | output | 1 | Any/all outcome, or the all-equal outcome for match-all |
| rsp_err_o | output | 1 | Illegal operation code |

## Verification
The bench builds the unit at its default of 32 lanes with 32-bit values. This reaches the full-width ballot and the complete 32-by-32 equality matrix.

Random values are drawn from a set of four, so match-any produces groups of varying size. Match-all is steered by directed all-equal and single-outlier cases.

Random active and participation vectors are chosen independently, so participating-but-inactive lanes regularly exercise the zeroing of non-effective lanes.

// File: rtl/vote_pkg.sv
package vote_pkg;
  typedef enum logic [2:0] {
    OP_BALLOT    = 3'd0,
    OP_ANY       = 3'd1,
    OP_ALL       = 3'd2,
    OP_MATCH_ANY = 3'd3,
    OP_MATCH_ALL = 3'd4,
    OP_ACTIVE    = 3'd5
  } vote_op_e;
endpackage

// File: rtl/vote_reduce.sv
module vote_reduce #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] eff_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] ballot_o,
  output logic             any_o,
  output logic             all_o
);
  assign ballot_o = pred_i & eff_i;
  assign any_o    = |ballot_o;
  // empty group: vacuously all-true
  assign all_o    = &(pred_i | ~eff_i);
endmodule

// File: rtl/match_eq.sv
module match_eq #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]       eff_i,
  input  logic [LANES*DW-1:0]    value_i,
  output logic [LANES*LANES-1:0] eq_o,
  output logic                   all_eq_o
);
  logic [LANES-1:0] row_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_col
      assign eq_o[i*LANES+j] = eff_i[i] & eff_i[j] &
                               (value_i[i*DW +: DW] == value_i[j*DW +: DW]);
    end
    assign row_ok[i] = ~eff_i[i] | (eq_o[i*LANES +: LANES] == eff_i);
  end

  assign all_eq_o = &row_ok;
endmodule

// File: rtl/warp_vote_unit.sv
module warp_vote_unit
  import vote_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [2:0]             req_op_i,
  input  logic [LANES-1:0]       active_i,
  input  logic [LANES-1:0]       part_i,
  input  logic [LANES-1:0]       pred_i,
  input  logic [LANES*DW-1:0]    value_i,
  output logic                   rsp_valid_o,
  input  logic                   rsp_ready_i,
  output logic [LANES*LANES-1:0] rsp_result_o,
  output logic                   rsp_flag_o,
  output logic                   rsp_err_o
);
  localparam int RW = LANES * LANES;

  logic [LANES-1:0] eff;
  logic [LANES-1:0] ballot;
  logic             any_v, all_v, all_eq;
  logic [RW-1:0]    eq_mat;
  logic [RW-1:0]    res_d;
  logic             flag_d, err_d;
  logic             fire;
  vote_op_e         op;

  assign eff = part_i & active_i;
  assign op  = vote_op_e'(req_op_i);

  vote_reduce #(.LANES(LANES)) u_reduce (
    .eff_i    (eff),
    .pred_i   (pred_i),
    .ballot_o (ballot),
    .any_o    (any_v),
    .all_o    (all_v)
  );

  match_eq #(.LANES(LANES), .DW(DW)) u_match (
    .eff_i    (eff),
    .value_i  (value_i),
    .eq_o     (eq_mat),
    .all_eq_o (all_eq)
  );

  always_comb begin
    flag_d = 1'b0;
    err_d  = 1'b0;
    unique case (op)
      OP_ANY:       flag_d = any_v;
      OP_ALL:       flag_d = all_v;
      OP_MATCH_ALL: flag_d = all_eq;
      OP_BALLOT, OP_MATCH_ANY, OP_ACTIVE: flag_d = 1'b0;
      default:      err_d  = 1'b1;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANES-1:0] word;
    always_comb begin
      unique case (op)
        OP_BALLOT:    word = ballot;
        OP_ANY:       word = {{(LANES-1){1'b0}}, any_v};
        OP_ALL:       word = {{(LANES-1){1'b0}}, all_v};
        OP_MATCH_ANY: word = eq_mat[i*LANES +: LANES];
        OP_MATCH_ALL: word = all_eq ? eff : '0;
        OP_ACTIVE:    word = active_i;
        default:      word = '0;
      endcase
    end
    assign res_d[i*LANES +: LANES] = eff[i] ? word : '0;
  end

  assign req_ready_o = ~rsp_valid_o | rsp_ready_i;
  assign fire        = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_result_o <= '0;
      rsp_flag_o   <= 1'b0;
      rsp_err_o    <= 1'b0;
    end else if (fire) begin
      rsp_valid_o  <= 1'b1;
      rsp_result_o <= res_d;
      rsp_flag_o   <= flag_d;
      rsp_err_o    <= err_d;
    end else if (rsp_ready_i) begin
      rsp_valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/vote_chk.sv
module vote_chk
  import vote_pkg::*;
#(
  parameter int LANES = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic                   req_ready_o,
  input logic [2:0]             req_op_i,
  input logic [LANES-1:0]       active_i,
  input logic [LANES-1:0]       part_i,
  input logic                   rsp_valid_o,
  input logic                   rsp_ready_i,
  input logic [LANES*LANES-1:0] rsp_result_o,
  input logic                   rsp_flag_o,
  input logic                   rsp_err_o
);
  logic             fire;
  logic [LANES-1:0] cap_eff;
  logic [2:0]       cap_op;
  logic             outside_bits, ballot_bad, self_miss;

  assign fire = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_eff <= '0;
      cap_op  <= 3'd0;
    end else if (fire) begin
      cap_eff <= part_i & active_i;
      cap_op  <= req_op_i;
    end
  end

  always_comb begin
    outside_bits = 1'b0;
    ballot_bad   = 1'b0;
    self_miss    = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!cap_eff[i] && (rsp_result_o[i*LANES +: LANES] != '0)) outside_bits = 1'b1;
      if ((rsp_result_o[i*LANES +: LANES] & ~cap_eff) != '0)       ballot_bad   = 1'b1;
      if (cap_eff[i] && !rsp_result_o[i*LANES + i])                self_miss    = 1'b1;
    end
  end

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_result_o) && $stable(rsp_flag_o) && $stable(rsp_err_o)));

  a_r9_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);

  a_r7_outside_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !outside_bits);

  a_r10_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_result_o == '0 && !rsp_flag_o));

  a_r1_ballot_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && cap_op == 3'd0) |-> !ballot_bad);

  a_r4_self_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && cap_op == 3'd3) |-> !self_miss);
endmodule

bind warp_vote_unit vote_chk #(.LANES(LANES)) u_vote_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_op_i     (req_op_i),
  .active_i     (active_i),
  .part_i       (part_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_result_o (rsp_result_o),
  .rsp_flag_o   (rsp_flag_o),
  .rsp_err_o    (rsp_err_o)
);

// File: tb/tb_warp_vote_unit.sv
`timescale 1ns/1ps
module tb_warp_vote_unit;
  localparam int LANES = 32;
  localparam int DW    = 32;
  localparam int RW    = LANES * LANES;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [2:0]       req_op = 3'd0;
  logic [LANES-1:0] act_s = '0, part_s = '0, pred_s = '0;
  logic [LANES*DW-1:0] value_flat = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [RW-1:0]    rsp_result;
  logic             rsp_flag, rsp_err;

  logic [DW-1:0] val_s [LANES];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < LANES; i++) value_flat[i*DW +: DW] = val_s[i];

  warp_vote_unit #(.LANES(LANES), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .active_i(act_s), .part_i(part_s), .pred_i(pred_s), .value_i(value_flat),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_result_o(rsp_result), .rsp_flag_o(rsp_flag), .rsp_err_o(rsp_err)
  );

  logic [RW-1:0] exp_res;
  logic          exp_flag, exp_err;

  task automatic model(input logic [2:0] op);
    logic [LANES-1:0] eff, w;
    bit anyp, allp, alleq;
    eff = part_s & act_s;
    anyp = 0; allp = 1; alleq = 1;
    for (int j = 0; j < LANES; j++) if (eff[j]) begin
      if (pred_s[j]) anyp = 1; else allp = 0;
      for (int k = 0; k < LANES; k++)
        if (eff[k] && val_s[k] != val_s[j]) alleq = 0;
    end
    exp_err = (op > 3'd5);
    exp_flag = (op == 3'd1) ? anyp : (op == 3'd2) ? allp : (op == 3'd4) ? alleq : 1'b0;
    exp_res = '0;
    for (int i = 0; i < LANES; i++) begin
      w = '0;
      case (op)
        3'd0: w = pred_s & eff;
        3'd1: w = {{(LANES-1){1'b0}}, anyp};
        3'd2: w = {{(LANES-1){1'b0}}, allp};
        3'd3: for (int j = 0; j < LANES; j++) w[j] = eff[j] && val_s[j] == val_s[i];
        3'd4: w = alleq ? eff : '0;
        3'd5: w = act_s;
        default: w = '0;
      endcase
      if (eff[i]) exp_res[i*LANES +: LANES] = w;
    end
  endtask

  function automatic string rtag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";  3'd1: return "R2";  3'd2: return "R3";
      3'd3: return "R4";  3'd4: return "R5";  3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic cmp_rsp(input string tag);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_result !== exp_res || rsp_flag !== exp_flag || rsp_err !== exp_err) begin
      errors++;
      $display("FAIL %s: valid=%b flag=%b err=%b res=%h | expected valid=1 flag=%b err=%b res=%h",
               tag, rsp_valid, rsp_flag, rsp_err, rsp_result, exp_flag, exp_err, exp_res);
    end
  endtask

  // drive at negedge, check after the accepting edge; returns at the next negedge
  task automatic issue(input logic [2:0] op, input string tag);
    req_op = op; req_valid = 1'b1; rsp_ready = 1'b1;
    model(op);
    @(posedge clk); #1;
    cmp_rsp(tag);
    @(negedge clk);
  endtask

  task automatic set_vals_const(input logic [DW-1:0] v);
    for (int i = 0; i < LANES; i++) val_s[i] = v;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] held;
    void'($urandom(32'd20240517));
    set_vals_const('0);
    #12;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_result !== '0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R8 reset: valid=%b ready=%b res=%h expected valid=0 ready=1 res=0",
               rsp_valid, req_ready, rsp_result);
    end
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R3: empty effective set (participating lanes all inactive)
    act_s = 32'h0000_FFFF; part_s = 32'hFFFF_0000; pred_s = '1;
    issue(3'd0, "R3 empty ballot");
    issue(3'd1, "R3 empty any");
    issue(3'd2, "R3 empty all");
    issue(3'd4, "R3 empty match-all");

    // R1/R7: ballot with partially inactive participants
    act_s = 32'hF0F0_FFFF; part_s = 32'h0FFF_FFF0; pred_s = 32'hAAAA_5555;
    issue(3'd0, "R1 ballot mixed R7");
    // R2/R3 all predicates set over effective lanes
    pred_s = act_s & part_s;
    issue(3'd2, "R3 all true");
    issue(3'd1, "R2 any true");
    pred_s = '0;
    issue(3'd1, "R2 any false");

    // R5: all equal, then one outlier
    act_s = '1; part_s = '1; set_vals_const(32'hDEAD_BEEF);
    issue(3'd4, "R5 all equal");
    val_s[17] = 32'h1234_5678;
    issue(3'd4, "R5 one outlier");
    // outlier excluded from participation -> equal again
    part_s[17] = 1'b0;
    issue(3'd4, "R5 outlier not participating R7");
    // R4 two groups
    for (int i = 0; i < LANES; i++) val_s[i] = i % 2;
    part_s = '1;
    issue(3'd3, "R4 two groups");
    // R6 active query with partial participation
    act_s = 32'h8123_4567; part_s = 32'h00FF_FF00;
    issue(3'd5, "R6 active query");
    // R10 illegal codes
    act_s = '1; part_s = '1; pred_s = '1;
    issue(3'd6, "R10 code 6");
    issue(3'd7, "R10 code 7");

    // R9: stall holds response and backpressures request
    issue(3'd0, "R9 stall setup");
    held = rsp_result;
    rsp_ready = 1'b0; pred_s = 32'h0000_0001; req_op = 3'd0; req_valid = 1'b1;
    #0.5;
    checks++;
    if (req_ready !== 1'b0) begin
      errors++; $display("FAIL R9 ready during stall: %b expected 0", req_ready);
    end
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_result !== held) begin
      errors++; $display("FAIL R9 held: valid=%b res=%h expected valid=1 res=%h", rsp_valid, rsp_result, held);
    end
    @(negedge clk);
    issue(3'd0, "R9 released R8");

    // R8 back-to-back random, R1..R10 by op
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      act_s = $urandom | $urandom; part_s = $urandom | $urandom; pred_s = $urandom;
      for (int i = 0; i < LANES; i++) val_s[i] = $urandom % 4;
      if (n % 7 == 0) set_vals_const(32'h5);
      issue(op, rtag(op));
    end

    req_valid = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R8 idle: valid=%b expected 0", rsp_valid);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule